// File: doc/BRIEF.md
# Time-Multiplexed Multi-Stream DMA Write Sequencer

This block merges five ready/valid sample streams from a signal-processing pipeline onto one 32-bit DMA write port. The streams are a phase word, a raw 24-bit sample, a filtered sample, an I/Q pair and a filtered I/Q pair. The block visits a fixed ring of fourteen slots. The ring is a reference set of seven slots followed by a sample set of seven slots. In each slot it accepts one beat from the stream that owns the slot.

A per-slot enable mask decides what happens to each accepted beat. An enabled beat is written to the DMA. A disabled beat is still taken from its stream and then dropped, so the pipeline never stalls on a slot that nobody wants.

The block works only while the DMA requests transfers. While no transfer is requested, it holds the processing pipeline in reset and parks its slot pointer on the first slot, so every capture starts with the reference phase word. A sticky flag reports DMA overflow for the current capture.

Top module: `tdm_dma_seq`

## Requirements
- R1: Within each set of seven slots, the owning streams are, in order: phase, raw, filtered, I/Q, I/Q, filtered I/Q, filtered I/Q. The reference set (slots 0 to 6) comes first and the sample set (slots 7 to 13) follows. Only the owning stream's ready output is high.
- R2: All five ready outputs are low while `xfer_req` is low. They are also low in the first cycle after `xfer_req` rises. At most one ready output is high at any time.
- R3: A slot completes on a clock edge where the owner's valid and ready are both high. The pointer then moves to the next slot, and slot 13 wraps to slot 0. While the owner's valid is low, the pointer holds and nothing is written.
- R4: After a completed slot s, `wr_en` is high for exactly the following cycle if bit s of `slot_en` is 1, with `wr_data` equal to the accepted beat. If bit s is 0, the beat is consumed and `wr_en` stays low. Bit 0 belongs to slot 0.
- R5: A raw-stream beat is written with bit 23 copied into bits 31:24.
- R6: On each I/Q stream, the first beat taken in a set fills the I slot and the next beat fills the Q slot. These are two consecutive completions on the same stream.
- R7: A clock edge with `xfer_req` low returns the pointer to slot 0. After a restart, the first ready is on the phase stream.
- R8: `pipe_rst_n` is `xfer_req` delayed by one register. It is low during reset.
- R9: `ovf_flag` goes high on the edge after `wr_ovf` is seen high, and stays high. It is cleared by reset or by the edge at which `xfer_req` rises. A clear wins over a set in the same cycle.
- R10: During reset, `wr_en`, `ovf_flag`, `pipe_rst_n` and all ready outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ph_vld | input | 1 | Phase stream valid |
| ph_rdy | output | 1 | Phase stream ready |
| ph_dat | input | 32 | Phase stream data |
| raw_vld | input | 1 | Raw sample valid |
| raw_rdy | output | 1 | Raw sample ready |
| raw_dat | input | 24 | Raw sample, two's complement |
| flt_vld | input | 1 | Filtered sample valid |
| flt_rdy | output | 1 | Filtered sample ready |
| flt_dat | input | 32 | Filtered sample data |
| iq_vld | input | 1 | I/Q stream valid |
| iq_rdy | output | 1 | I/Q stream ready |
| iq_dat | input | 32 | I/Q stream data, I beat then Q beat |
| iqf_vld | input | 1 | Filtered I/Q valid |
| iqf_rdy | output | 1 | Filtered I/Q ready |
| iqf_dat | input | 32 | Filtered I/Q data, I beat then Q beat |
| wr_en | output | 1 | DMA write strobe |
| wr_data | output | 32 | DMA write word |
| wr_ovf | input | 1 | DMA overflow indication |
| xfer_req | input | 1 | DMA transfer request |
| slot_en | input | 14 | Per-slot forward enable |
| pipe_rst_n | output | 1 | Active-low reset for the processing pipeline |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A corrupted slot pointer shows in the same cycle as a ready on the wrong stream, because ready decodes the pointer directly. One cycle later it also shows as a write gated by the wrong enable bit. A fault in the sign extension or the data select shows on `wr_data` one cycle after the handshake. A pointer that is not cleared on a restart shows as a first ready on a stream other than phase. The overflow and pipeline-reset registers are each checked one edge after their cause.

// File: rtl/tdm_seq_pkg.sv
`timescale 1ns/1ps
package tdm_seq_pkg;

   localparam int SET_LEN   = 7;
   localparam int N_STREAMS = 5;

   typedef enum logic [2:0] {
      ST_PH  = 3'd0,
      ST_RAW = 3'd1,
      ST_FLT = 3'd2,
      ST_IQ  = 3'd3,
      ST_IQF = 3'd4
   } stream_e;

   // owner of a position inside one set; I/Q streams take two positions each
   function automatic stream_e pos_owner(input logic [2:0] pos);
      case (pos)
         3'd0:       return ST_PH;
         3'd1:       return ST_RAW;
         3'd2:       return ST_FLT;
         3'd3, 3'd4: return ST_IQ;
         default:    return ST_IQF;
      endcase
   endfunction

endpackage

// File: rtl/tdm_slot_ctr.sv
`timescale 1ns/1ps
module tdm_slot_ctr
   import tdm_seq_pkg::*;
#(
   parameter int N_SETS = 2,
   localparam int N_SLOTS = SET_LEN * N_SETS,
   localparam int SW      = $clog2(N_SLOTS),
   localparam int SETW    = (N_SETS > 1) ? $clog2(N_SETS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          adv,
   output logic [SW-1:0] slot_o,
   output stream_e       stream_o,
   output logic          last_o
);

   logic [2:0]      pos_q;
   logic [SETW-1:0] set_q;
   logic            pos_end;
   logic            set_end;

   generate
      if (N_SETS < 1) begin : g_bad_sets
         $error("tdm_slot_ctr: N_SETS must be at least 1");
      end
   endgenerate

   assign pos_end = (pos_q == 3'(SET_LEN - 1));
   assign set_end = (set_q == SETW'(N_SETS - 1));
   assign last_o  = pos_end && set_end;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         pos_q <= '0;
         set_q <= '0;
      end else if (adv) begin
         if (pos_end) begin
            pos_q <= '0;
            set_q <= set_end ? '0 : set_q + 1'b1;
         end else begin
            pos_q <= pos_q + 1'b1;
         end
      end
   end

   assign slot_o   = SW'(int'(set_q) * SET_LEN + int'(pos_q));
   assign stream_o = pos_owner(pos_q);

   a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      run && adv && !last_o |=> slot_o == SW'($past(slot_o) + 1'b1));

   a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      run && adv && last_o |=> slot_o == '0);

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      run && !adv |=> slot_o == $past(slot_o));

   a_r7_park: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> slot_o == '0);

endmodule

// File: rtl/tdm_port_mux.sv
`timescale 1ns/1ps
module tdm_port_mux
   import tdm_seq_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int RAW_W  = 24
) (
   input  logic                 act,
   input  stream_e              stream,
   input  logic [N_STREAMS-1:0] vld,
   output logic [N_STREAMS-1:0] rdy,
   output logic                 hs,
   input  logic [DATA_W-1:0]    ph_dat,
   input  logic [RAW_W-1:0]     raw_dat,
   input  logic [DATA_W-1:0]    flt_dat,
   input  logic [DATA_W-1:0]    iq_dat,
   input  logic [DATA_W-1:0]    iqf_dat,
   output logic [DATA_W-1:0]    sel_dat
);

   logic [DATA_W-1:0] raw_ext;

   generate
      if (RAW_W < 2 || RAW_W > DATA_W) begin : g_bad_raw
         $error("tdm_port_mux: RAW_W must lie in 2..DATA_W");
      end else if (RAW_W == DATA_W) begin : g_raw_full
         assign raw_ext = raw_dat;
      end else begin : g_raw_sext
         assign raw_ext = {{(DATA_W - RAW_W){raw_dat[RAW_W-1]}}, raw_dat};
      end
   endgenerate

   generate
      for (genvar i = 0; i < N_STREAMS; i++) begin : g_rdy
         assign rdy[i] = act && (stream == stream_e'(i));
      end
   endgenerate

   assign hs = |(rdy & vld);

   always_comb begin
      case (stream)
         ST_PH:   sel_dat = ph_dat;
         ST_RAW:  sel_dat = raw_ext;
         ST_FLT:  sel_dat = flt_dat;
         ST_IQ:   sel_dat = iq_dat;
         default: sel_dat = iqf_dat;
      endcase
   end

endmodule

// File: rtl/tdm_wr_stage.sv
`timescale 1ns/1ps
module tdm_wr_stage #(
   parameter int DATA_W  = 32,
   parameter int N_SLOTS = 14,
   localparam int SW     = $clog2(N_SLOTS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               xfer_req,
   input  logic               hs,
   input  logic [SW-1:0]      slot,
   input  logic [N_SLOTS-1:0] slot_en,
   input  logic [DATA_W-1:0]  sel_dat,
   input  logic               wr_ovf,
   output logic               act,
   output logic               wr_en,
   output logic [DATA_W-1:0]  wr_data,
   output logic               pipe_rst_n,
   output logic               ovf_flag
);

   logic xfer_q;
   logic xfer_rise;

   assign xfer_rise  = xfer_req && !xfer_q;
   assign act        = xfer_req && xfer_q;
   assign pipe_rst_n = xfer_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xfer_q   <= 1'b0;
         ovf_flag <= 1'b0;
         wr_en    <= 1'b0;
         wr_data  <= '0;
      end else begin
         xfer_q <= xfer_req;
         if (xfer_rise)
            ovf_flag <= 1'b0;
         else if (wr_ovf)
            ovf_flag <= 1'b1;
         wr_en <= hs && slot_en[slot];
         if (hs)
            wr_data <= sel_dat;
      end
   end

   a_r4_fwd: assert property (@(posedge clk) disable iff (!rst_n)
      hs && slot_en[slot] |=> wr_en && (wr_data == $past(sel_dat)));

   a_r4_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs && slot_en[slot]) |=> !wr_en);

   a_r8_pipe: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_req |=> !pipe_rst_n);

   a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ovf && !xfer_rise |=> ovf_flag);

   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_rise |=> !ovf_flag);

endmodule

// File: rtl/tdm_dma_seq.sv
`timescale 1ns/1ps
module tdm_dma_seq
   import tdm_seq_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int RAW_W  = 24,
   parameter int N_SETS = 2,
   localparam int N_SLOTS = SET_LEN * N_SETS,
   localparam int SW      = $clog2(N_SLOTS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ph_vld,
   output logic               ph_rdy,
   input  logic [DATA_W-1:0]  ph_dat,
   input  logic               raw_vld,
   output logic               raw_rdy,
   input  logic [RAW_W-1:0]   raw_dat,
   input  logic               flt_vld,
   output logic               flt_rdy,
   input  logic [DATA_W-1:0]  flt_dat,
   input  logic               iq_vld,
   output logic               iq_rdy,
   input  logic [DATA_W-1:0]  iq_dat,
   input  logic               iqf_vld,
   output logic               iqf_rdy,
   input  logic [DATA_W-1:0]  iqf_dat,
   output logic               wr_en,
   output logic [DATA_W-1:0]  wr_data,
   input  logic               wr_ovf,
   input  logic               xfer_req,
   input  logic [N_SLOTS-1:0] slot_en,
   output logic               pipe_rst_n,
   output logic               ovf_flag
);

   logic [SW-1:0]        slot;
   stream_e              stream;
   logic                 last;
   logic                 act;
   logic                 hs;
   logic [N_STREAMS-1:0] vld;
   logic [N_STREAMS-1:0] rdy;
   logic [DATA_W-1:0]    sel_dat;

   assign vld[ST_PH]  = ph_vld;
   assign vld[ST_RAW] = raw_vld;
   assign vld[ST_FLT] = flt_vld;
   assign vld[ST_IQ]  = iq_vld;
   assign vld[ST_IQF] = iqf_vld;

   assign ph_rdy  = rdy[ST_PH];
   assign raw_rdy = rdy[ST_RAW];
   assign flt_rdy = rdy[ST_FLT];
   assign iq_rdy  = rdy[ST_IQ];
   assign iqf_rdy = rdy[ST_IQF];

   tdm_slot_ctr #(.N_SETS(N_SETS)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (xfer_req),
      .adv      (hs),
      .slot_o   (slot),
      .stream_o (stream),
      .last_o   (last)
   );

   tdm_port_mux #(.DATA_W(DATA_W), .RAW_W(RAW_W)) u_mux (
      .act     (act),
      .stream  (stream),
      .vld     (vld),
      .rdy     (rdy),
      .hs      (hs),
      .ph_dat  (ph_dat),
      .raw_dat (raw_dat),
      .flt_dat (flt_dat),
      .iq_dat  (iq_dat),
      .iqf_dat (iqf_dat),
      .sel_dat (sel_dat)
   );

   tdm_wr_stage #(.DATA_W(DATA_W), .N_SLOTS(N_SLOTS)) u_wr (
      .clk        (clk),
      .rst_n      (rst_n),
      .xfer_req   (xfer_req),
      .hs         (hs),
      .slot       (slot),
      .slot_en    (slot_en),
      .sel_dat    (sel_dat),
      .wr_ovf     (wr_ovf),
      .act        (act),
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .pipe_rst_n (pipe_rst_n),
      .ovf_flag   (ovf_flag)
   );

   a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_req |-> rdy == '0);

   a_r2_single: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ph_rdy, raw_rdy, flt_rdy, iq_rdy, iqf_rdy}));

   a_r7_phase_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pipe_rst_n) && xfer_req |-> ph_rdy);

   a_r1_wrap_phase: assert property (@(posedge clk) disable iff (!rst_n)
      hs && last && xfer_req |=> (slot == '0));

endmodule

// File: tb/test_tdm_dma_seq.sv
`timescale 1ns/1ps
module test_tdm_dma_seq;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [4:0]  vmask;
   logic [31:0] ph_d, flt_d, iq_d, iqf_d;
   logic [23:0] raw_d;
   logic        ph_rdy, raw_rdy, flt_rdy, iq_rdy, iqf_rdy;
   logic        wr_en;
   logic [31:0] wr_data;
   logic        wr_ovf;
   logic        xfer_req;
   logic [13:0] slot_en;
   logic        pipe_rst_n;
   logic        ovf_flag;
   logic [4:0]  rdy;

   int n_tests = 0;
   int n_fail  = 0;
   int slot_m  = 0;
   int seq     = 0;

   always #10 clk = ~clk;

   assign rdy = {iqf_rdy, iq_rdy, flt_rdy, raw_rdy, ph_rdy};

   tdm_dma_seq i_tdm_dma_seq (
      .clk(clk), .rst_n(rst_n),
      .ph_vld(vmask[0]),  .ph_rdy(ph_rdy),   .ph_dat(ph_d),
      .raw_vld(vmask[1]), .raw_rdy(raw_rdy), .raw_dat(raw_d),
      .flt_vld(vmask[2]), .flt_rdy(flt_rdy), .flt_dat(flt_d),
      .iq_vld(vmask[3]),  .iq_rdy(iq_rdy),   .iq_dat(iq_d),
      .iqf_vld(vmask[4]), .iqf_rdy(iqf_rdy), .iqf_dat(iqf_d),
      .wr_en(wr_en), .wr_data(wr_data), .wr_ovf(wr_ovf),
      .xfer_req(xfer_req), .slot_en(slot_en),
      .pipe_rst_n(pipe_rst_n), .ovf_flag(ovf_flag)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int owner(input int slot);
      case (slot % 7)
         0: return 0;
         1: return 1;
         2: return 2;
         3, 4: return 3;
         default: return 4;
      endcase
   endfunction

   // one slot attempt; own_vld=0 leaves the owner's valid low
   task automatic beat(input bit own_vld);
      int st = owner(slot_m);
      logic [31:0] exp_d;
      seq++;
      ph_d  = 32'hC100_0000 + seq;
      raw_d = seq[0] ? (24'h80_0000 | 24'(seq)) : (24'h12_0000 | 24'(seq));
      flt_d = 32'h0F00_0000 + seq;
      iq_d  = 32'h7700_0000 + seq;
      iqf_d = 32'hE900_0000 + seq;
      vmask = own_vld ? 5'b11111 : ~(5'(1) << st);
      case (st)
         0: exp_d = ph_d;
         1: exp_d = {{8{raw_d[23]}}, raw_d};
         2: exp_d = flt_d;
         3: exp_d = iq_d;
         default: exp_d = iqf_d;
      endcase
      #1;
      check(rdy == (5'(1) << st), "R1 owner ready", 32'(rdy), 32'(5'(1) << st));
      @(posedge clk); @(negedge clk);
      if (own_vld) begin
         check(wr_en == slot_en[slot_m], "R4 write strobe", 32'(wr_en), 32'(slot_en[slot_m]));
         if (slot_en[slot_m])
            check(wr_data == exp_d, (st == 1) ? "R5 raw extension" : "R4 data", wr_data, exp_d);
         slot_m = (slot_m + 1) % 14;
      end else begin
         check(wr_en == 1'b0, "R3 stall no write", 32'(wr_en), 32'd0);
      end
   endtask

   task automatic start_capture();
      xfer_req = 1'b1;
      #1;
      check(rdy == 5'd0, "R2 ready low on first request cycle", 32'(rdy), 32'd0);
      @(posedge clk); @(negedge clk);
      check(pipe_rst_n == 1'b1, "R8 pipe reset released", 32'(pipe_rst_n), 32'd1);
      slot_m = 0;
   endtask

   task automatic t_reset();
      check(rdy == 5'd0 && wr_en == 1'b0, "R10 reset outputs", {27'd0, rdy} | 32'(wr_en), 32'd0);
      check(pipe_rst_n == 1'b0 && ovf_flag == 1'b0, "R10 reset flags", {pipe_rst_n, ovf_flag}, 32'd0);
   endtask

   task automatic t_idle();
      vmask = 5'b11111;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(rdy == 5'd0, "R2 idle no ready", 32'(rdy), 32'd0);
      check(pipe_rst_n == 1'b0, "R8 idle pipe reset", 32'(pipe_rst_n), 32'd0);
      check(wr_en == 1'b0, "R4 idle no write", 32'(wr_en), 32'd0);
   endtask

   task automatic t_full_ring();
      slot_en = 14'h3FFF;
      start_capture();
      // R6: slots 3,4 and 5,6 are consecutive I/Q beats on one stream
      for (int k = 0; k < 16; k++) beat(1'b1);
      check(slot_m == 2, "R3 wrap through slot 13", 32'(slot_m), 32'd2);
   endtask

   task automatic t_mask();
      slot_en = 14'b10_1100_0110_1001;
      for (int k = 0; k < 14; k++) beat(1'b1);
      slot_en = 14'h0000;
      for (int k = 0; k < 3; k++) beat(1'b1);
   endtask

   task automatic t_stall();
      slot_en = 14'h3FFF;
      beat(1'b0);
      beat(1'b0);
      beat(1'b1);
      beat(1'b1);
   endtask

   task automatic t_restart();
      xfer_req = 1'b0;
      #1;
      check(rdy == 5'd0, "R2 ready drops with request", 32'(rdy), 32'd0);
      @(posedge clk); @(negedge clk);
      check(pipe_rst_n == 1'b0, "R8 pipe reset reasserted", 32'(pipe_rst_n), 32'd0);
      start_capture();
      check(ph_rdy == 1'b1, "R7 restart at phase slot", 32'(ph_rdy), 32'd1);
      beat(1'b1);
      beat(1'b1);
   endtask

   task automatic t_overflow();
      wr_ovf = 1'b1;
      @(posedge clk); @(negedge clk);
      wr_ovf = 1'b0;
      check(ovf_flag == 1'b1, "R9 overflow set", 32'(ovf_flag), 32'd1);
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(ovf_flag == 1'b1, "R9 overflow sticky", 32'(ovf_flag), 32'd1);
      xfer_req = 1'b0;
      @(posedge clk); @(negedge clk);
      check(ovf_flag == 1'b1, "R9 held while idle", 32'(ovf_flag), 32'd1);
      xfer_req = 1'b1;
      wr_ovf   = 1'b1;
      @(posedge clk); @(negedge clk);
      wr_ovf = 1'b0;
      check(ovf_flag == 1'b0, "R9 clear wins on request rise", 32'(ovf_flag), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; xfer_req = 1'b0; wr_ovf = 1'b0; slot_en = '0;
      vmask = 5'b00000; ph_d = '0; raw_d = '0; flt_d = '0; iq_d = '0; iqf_d = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_idle();
      t_full_ring();
      t_mask();
      t_stall();
      t_restart();
      t_overflow();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule